// File: doc/BRIEF.md
# LPC Legacy and Firmware Address Decoder

This block decides, for every host cycle, whether the cycle belongs on the LPC bus. An I/O cycle is forwarded when its port address falls in one of thirteen legacy port groups whose enable bit is set. A memory cycle is forwarded when its address falls in one of two firmware windows whose enable bit is set. The decision is purely combinational, so the result is ready in the same cycle the request is presented. A hit code reports which range matched.

Two enable registers are held in the block. Software reaches them through a 32-bit configuration port with byte enables. The firmware enables do not reset to a constant. Instead they are preset from a firmware-present strap, which is captured when a synchronized power-good input rises.

Top module: `lpc_addr_decode`

## Requirements
- R1: After reset both registers read zero, and no cycle is routed.
- R2: The I/O-enable register occupies bytes E6h (lanes 2, bits 7:0 of the register) and E7h (lane 3, bits 15:8) of dword E4h. Register bits 15:13 are reserved: writes to them are ignored and they read 0.
- R3: The firmware-enable register is byte E3h, which is lane 3 of dword E0h. It is fully writable.
- R4: Writes take effect on the next rising clock edge, and only in the lanes whose byte enable is set. Reads of any other dword return zero.
- R5: For an I/O cycle (req_is_io=1, address bits 31:16 zero), each enable bit routes the following ports:
  - bit 0: 3F8h–3FFh
  - bit 1: 2F8h–2FFh
  - bit 2: 378h–37Fh
  - bit 3: 3F0h–3F5h and 3F7h
  - bit 4: 220h–233h
  - bit 5: 330h–331h
  - bit 6: 388h–38Bh
  - bit 7: 200h–20Fh
  - bit 8: 60h and 64h
  - bit 9: 530h–537h
  - bit 10: 62h and 66h
  - bit 11: 2Eh–2Fh
  - bit 12: 4Eh–4Fh
- R6: For a memory cycle, firmware bit 6 routes FFF00000h–FFF7FFFFh and FFB00000h–FFB7FFFFh. Firmware bit 7 routes FFF80000h–FFFFFFFFh, FFB80000h–FFBFFFFFh and 000E0000h–000FFFFFh. Firmware bits 5:0 route nothing.
- R7: route_lpc is high only when the request is valid and hits an enabled range. Otherwise hit_code is 1Fh.
- R8: hit_code is the number of the lowest enabled matching I/O bit, or 16 for firmware bit 6, or 17 for firmware bit 7. The code is valid in the same cycle as the request.
- R9: On the rising edge of power-good, after a two-stage synchronizer, the firmware-enable register is loaded with 00h if the strap reads 1 and with FFh if it reads 0. This happens no later than four clocks after the input rises, and the preset wins over a same-cycle write.
- R10: While power-good stays high, changes of the strap have no effect. A new capture happens only after power-good falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good, asynchronous |
| fw_absent_strap | input | 1 | Strap level; 1 means no firmware |
| cfg_addr | input | 8 | Configuration byte address (bits 1:0 ignored) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| req_valid | input | 1 | Host cycle present |
| req_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_addr | input | 32 | Host cycle address |
| route_lpc | output | 1 | Forward the cycle to LPC |
| hit_code | output | 5 | Matching range code, 1Fh for none |

## Verification
The decoder is exercised with addresses at, just inside and just outside every range edge. These cases separate off-by-one errors in range limits, and the floppy gap at 3F6h tells a hole in a range apart from a plain span. Random enable masks are combined with addresses drawn near the ranges, with both cycle types and with valid toggling. This shows that each bit gates only its own ports and that I/O and memory decoding never leak into each other. Power-good is pulsed with both strap levels, and the strap is changed while power-good stays high. This tells a one-time edge capture apart from a level-sensitive load.

// File: rtl/lpc_addr_decode.sv
module lpc_addr_decode #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] IO_EN_DW = 8'hE4,
  parameter logic [7:0] FW_EN_DW = 8'hE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_good,
  input  logic        fw_absent_strap,
  input  logic [7:0]  cfg_addr,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic        req_is_io,
  input  logic [31:0] req_addr,
  output logic        route_lpc,
  output logic [4:0]  hit_code
);
  localparam int IO_BITS = 13;
  localparam logic [4:0] NO_HIT = 5'h1F;

  logic [IO_BITS-1:0] io_en;
  logic [7:0]         fw_en;
  logic [SYNC_STAGES-1:0] pg_sync;
  logic               pg_seen;
  logic               pg_rise;

  wire sel_io = cfg_addr[7:2] == IO_EN_DW[7:2];
  wire sel_fw = cfg_addr[7:2] == FW_EN_DW[7:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_sync <= '0;
      pg_seen <= 1'b0;
    end else begin
      pg_sync <= {pg_sync[SYNC_STAGES-2:0], pwr_good};
      pg_seen <= pg_sync[SYNC_STAGES-1];
    end

  assign pg_rise = pg_sync[SYNC_STAGES-1] & ~pg_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      io_en <= '0;
    end else if (cfg_wr && sel_io) begin
      if (cfg_be[2]) io_en[7:0]  <= cfg_wdata[23:16];
      if (cfg_be[3]) io_en[12:8] <= cfg_wdata[28:24];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      fw_en <= '0;
    else if (pg_rise)
      fw_en <= fw_absent_strap ? 8'h00 : 8'hFF;
    else if (cfg_wr && sel_fw && cfg_be[3])
      fw_en <= cfg_wdata[31:24];

  always_comb begin
    cfg_rdata = '0;
    if (sel_io) cfg_rdata[28:16] = io_en;
    else if (sel_fw) cfg_rdata[31:24] = fw_en;
  end

  wire [15:0] p = req_addr[15:0];
  wire io_ok = req_is_io && req_addr[31:16] == 16'h0;
  logic [IO_BITS-1:0] io_match;

  assign io_match[0]  = p >= 16'h3F8 && p <= 16'h3FF;
  assign io_match[1]  = p >= 16'h2F8 && p <= 16'h2FF;
  assign io_match[2]  = p >= 16'h378 && p <= 16'h37F;
  assign io_match[3]  = (p >= 16'h3F0 && p <= 16'h3F5) || p == 16'h3F7;
  assign io_match[4]  = p >= 16'h220 && p <= 16'h233;
  assign io_match[5]  = p == 16'h330 || p == 16'h331;
  assign io_match[6]  = p >= 16'h388 && p <= 16'h38B;
  assign io_match[7]  = p >= 16'h200 && p <= 16'h20F;
  assign io_match[8]  = p == 16'h60 || p == 16'h64;
  assign io_match[9]  = p >= 16'h530 && p <= 16'h537;
  assign io_match[10] = p == 16'h62 || p == 16'h66;
  assign io_match[11] = p == 16'h2E || p == 16'h2F;
  assign io_match[12] = p == 16'h4E || p == 16'h4F;

  wire [12:0] hi = req_addr[31:19];
  wire fw6_match = hi == 13'h1FFE || hi == 13'h1FF6;
  wire fw7_match = hi == 13'h1FFF || hi == 13'h1FF7 || req_addr[31:17] == 15'h0007;

  wire [IO_BITS-1:0] io_hits = io_match & io_en & {IO_BITS{io_ok & req_valid}};
  wire mem_cyc = req_valid & ~req_is_io;
  wire fw6_hit = mem_cyc & fw6_match & fw_en[6];
  wire fw7_hit = mem_cyc & fw7_match & fw_en[7];

  always_comb begin
    hit_code = NO_HIT;
    if (fw7_hit) hit_code = 5'd17;
    if (fw6_hit) hit_code = 5'd16;
    for (int i = IO_BITS - 1; i >= 0; i--)
      if (io_hits[i]) hit_code = 5'(i);
  end

  assign route_lpc = hit_code != NO_HIT;

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_io |-> cfg_rdata[31:29] == 3'b0);
  p_write_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && sel_io && cfg_be[2]) |=> io_en[7:0] == $past(cfg_wdata[23:16]));
  p_no_hit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!route_lpc && hit_code == NO_HIT));
  p_mem_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_lpc && !req_is_io) |-> (hit_code == 5'd16 || hit_code == 5'd17));
  p_io_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_lpc && req_is_io) |-> hit_code < 5'd13);
  p_strap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_rise |=> fw_en == ($past(fw_absent_strap) ? 8'h00 : 8'hFF));
  p_strap_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_rise && !(cfg_wr && sel_fw && cfg_be[3])) |=> $stable(fw_en));
endmodule

// File: tb/lpc_addr_decode_tb.sv
module lpc_addr_decode_tb;
  logic clk = 0, rst_n = 0, pwr_good = 0, strap = 0;
  logic [7:0] cfg_addr = 0;
  logic cfg_wr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_is_io = 0;
  logic [31:0] req_addr = 0;
  logic route_lpc;
  logic [4:0] hit_code;
  int checks = 0, errors = 0;
  logic [12:0] m_io = 0;
  logic [7:0] m_fw = 0;

  always #2 clk = ~clk;

  lpc_addr_decode u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .fw_absent_strap(strap),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .route_lpc(route_lpc), .hit_code(hit_code));

  function automatic logic [4:0] exp_code(logic v, logic io, logic [31:0] a, logic [12:0] ie, logic [7:0] fe);
    logic [12:0] m;
    logic [15:0] q;
    if (!v) return 5'h1F;
    if (!io) begin
      if (fe[6] && ((a >= 32'hFFF00000 && a <= 32'hFFF7FFFF) || (a >= 32'hFFB00000 && a <= 32'hFFB7FFFF))) return 5'd16;
      if (fe[7] && (a >= 32'hFFF80000 || (a >= 32'hFFB80000 && a <= 32'hFFBFFFFF) || (a >= 32'h000E0000 && a <= 32'h000FFFFF))) return 5'd17;
      return 5'h1F;
    end
    if (a[31:16] != 0) return 5'h1F;
    q = a[15:0];
    m[0] = q inside {[16'h3F8:16'h3FF]};
    m[1] = q inside {[16'h2F8:16'h2FF]};
    m[2] = q inside {[16'h378:16'h37F]};
    m[3] = q inside {[16'h3F0:16'h3F5], 16'h3F7};
    m[4] = q inside {[16'h220:16'h233]};
    m[5] = q inside {16'h330, 16'h331};
    m[6] = q inside {[16'h388:16'h38B]};
    m[7] = q inside {[16'h200:16'h20F]};
    m[8] = q inside {16'h60, 16'h64};
    m[9] = q inside {[16'h530:16'h537]};
    m[10] = q inside {16'h62, 16'h66};
    m[11] = q inside {16'h2E, 16'h2F};
    m[12] = q inside {16'h4E, 16'h4F};
    for (int i = 0; i < 13; i++) if (m[i] && ie[i]) return 5'(i);
    return 5'h1F;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    if (a[7:2] == 6'h39) begin
      if (be[2]) m_io[7:0] = d[23:16];
      if (be[3]) m_io[12:8] = d[28:24];
    end
    if (a[7:2] == 6'h38 && be[3]) m_fw = d[31:24];
  endtask

  task automatic cfg_read(string req, logic [7:0] a, logic [31:0] exp);
    cfg_addr = a; #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic probe(string req, logic v, logic io, logic [31:0] a);
    logic [4:0] e;
    req_valid = v; req_is_io = io; req_addr = a; #1;
    e = exp_code(v, io, a, m_io, m_fw);
    chk({req, " code"}, 32'(hit_code), 32'(e));
    chk({req, " route"}, 32'(route_lpc), 32'(e != 5'h1F));
  endtask

  task automatic pg_pulse(logic level);
    @(negedge clk); pwr_good = level;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cfg_read("R1 io reset", 8'hE6, 32'h0);
    cfg_read("R1 fw reset", 8'hE3, 32'h0);
    probe("R1 no route", 1, 1, 32'h3F8);

    cfg_write(8'hE4, 4'hC, 32'hFFFF_FFFF);
    cfg_read("R2 reserved bits", 8'hE4, 32'h1FFF_0000);
    cfg_write(8'hE4, 4'h4, 32'h0);
    cfg_read("R4 lane2 only", 8'hE4, 32'h1F00_0000);
    cfg_write(8'hE4, 4'h3, 32'h0);
    cfg_read("R4 lanes0-1 ignored", 8'hE4, 32'h1F00_0000);
    cfg_read("R4 unimplemented", 8'h40, 32'h0);
    cfg_write(8'hE0, 4'h7, 32'hFFFF_FFFF);
    cfg_read("R3 low lanes ignored", 8'hE0, 32'h0);
    cfg_write(8'hE0, 4'h8, 32'hA5_000000);
    cfg_read("R3 fw write", 8'hE3, 32'hA500_0000);

    strap = 0; pg_pulse(1);
    m_fw = 8'hFF;
    cfg_read("R9 strap 0 presets FF", 8'hE0, 32'hFF00_0000);
    strap = 1; repeat (6) @(negedge clk);
    cfg_read("R10 strap ignored", 8'hE0, 32'hFF00_0000);
    cfg_write(8'hE0, 4'h8, 32'h4000_0000);
    strap = 0; repeat (4) @(negedge clk);
    cfg_read("R10 write kept", 8'hE0, 32'h4000_0000);
    pg_pulse(0);
    strap = 1; pg_pulse(1);
    m_fw = 8'h00;
    cfg_read("R9 strap 1 clears", 8'hE0, 32'h0);

    cfg_write(8'hE4, 4'hC, 32'hFFFF_FFFF);
    cfg_write(8'hE0, 4'h8, 32'hC000_0000);
    probe("R5 floppy gap", 1, 1, 32'h3F6);
    probe("R5 floppy 3F7", 1, 1, 32'h3F7);
    probe("R5 sb16 edge", 1, 1, 32'h233);
    probe("R5 sb16 past", 1, 1, 32'h234);
    probe("R5 io high bits", 1, 1, 32'h0001_0060);
    probe("R6 fw6 top", 1, 0, 32'hFFF7_FFFF);
    probe("R6 fw7 low", 1, 0, 32'hFFF8_0000);
    probe("R6 shadow", 1, 0, 32'h000E_0000);
    probe("R6 below shadow", 1, 0, 32'h000D_FFFF);
    probe("R6 io not mem", 1, 1, 32'hFFF8_0000);
    probe("R7 invalid", 0, 1, 32'h60);
    probe("R8 keyboard", 1, 1, 32'h64);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] base, a;
      if (n % 50 == 0) begin
        cfg_write(8'hE4, 4'hC, $urandom);
        cfg_write(8'hE0, 4'h8, $urandom);
      end
      case ($urandom_range(0, 5))
        0: base = 32'hFFF80000;
        1: base = 32'hFFB80000;
        2: base = 32'h000E0000;
        default: base = 32'h0000_0200;
      endcase
      a = base + 32'($urandom_range(0, 16'h400)) - 32'h200;
      if (base[31:16] != 0 || base == 32'h000E0000) a = base + ($urandom & 32'h000F_FFFF) - 32'h0008_0000;
      @(negedge clk);
      probe("R8 random", $urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1, a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule